// File: doc/BRIEF.md
# Debug Exception Entry and Return Unit

This unit is the control slice of a 32-bit core's system coprocessor that moves the core into and out of debug mode, and out of the normal and error exception levels. When the pipeline raises a debug exception request, the unit rewrites the exception-type fields of its debug control word and marks the core as being in debug mode with further exceptions inhibited. It records where to resume in a debug return address register, and it steers fetch to a fixed debug vector in the standard 32-bit instruction set.

When a decoded system-coprocessor instruction of the debug-return kind executes, the unit leaves debug mode and sends fetch back to the recorded address. When an exception-return instruction executes, it drops the error level if that is set and the exception level otherwise. It sends fetch to the matching saved address, asks the core to clear its load-linked flag, and hands back an updated status word for the status register. Bit 0 of every saved return address carries the compressed-instruction mode, so each redirect also reports the instruction-set mode to resume in.

All redirects, the status write and the load-linked clear come out combinationally in the cycle of the request. The debug control word and the debug return address are registered and show their new values after the next clock edge.

Top module: `dbgx_unit`

## Requirements
- R1: While reset is held, the debug control word and the debug return address read zero and no redirect, status write or load-linked clear is raised.
- R2: On debug entry the type field (bits 0 to 5, bits 10 to 14 and bits 18 and 19 of the debug control word) is cleared and then loaded from the same bits of `dbg_type`, even when bit 30 is already set. The other bits of `dbg_type` have no effect.
- R3: On debug entry, bit 30 (in debug mode) and bit 20 (exceptions inhibited) of the debug control word are set, and bit 31 takes the value of `in_slot`. Every bit outside the type field and bits 20, 30 and 31 keeps its value.
- R4: On debug entry the debug return address becomes `cur_pc` minus 4 when `in_slot` is high and `cur_pc` otherwise, ORed with `cur_compact` in bit 0. No other event changes it.
- R5: In the cycle of a debug entry, `redir_vld` is high, `redir_pc` is `DBG_VECTOR` (default 0xBFC00480) and `isa_nxt` is 0.
- R6: A debug return (`instr_vld` with `cop0_func` equal to 0x1F) clears bits 30 and 20 of the debug control word at the next edge. In its own cycle it redirects to the debug return address with bit 0 cleared, with `isa_nxt` equal to that address's bit 0. It raises no status write and no load-linked clear.
- R7: An exception return (`cop0_func` equal to 0x18) with `status_in` bit 2 set writes `status_in` with bit 2 cleared and raises `ll_clr`. It redirects to `err_ret_pc` with bit 0 cleared and sets `isa_nxt` to `err_ret_pc` bit 0.
- R8: An exception return with `status_in` bit 2 clear writes `status_in` with bit 1 cleared and raises `ll_clr`. It redirects to `exc_ret_pc` with bit 0 cleared and sets `isa_nxt` to `exc_ret_pc` bit 0.
- R9: Any other function code (0x20 included), or `instr_vld` low without a debug request, raises no redirect, no status write and no load-linked clear, and leaves both registers unchanged.
- R10: A debug request has priority over an instruction in the same cycle. That instruction has no effect on any output or register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_pc | input | 32 | Address of the instruction taking the debug exception |
| cur_compact | input | 1 | Core is currently in compressed-instruction mode |
| in_slot | input | 1 | Excepting instruction sits in a branch delay slot |
| dbg_req | input | 1 | Debug exception request |
| dbg_type | input | 32 | Requested exception type bits, in debug control word positions |
| instr_vld | input | 1 | A system-coprocessor instruction executes this cycle |
| cop0_func | input | 6 | Function code of that instruction |
| status_in | input | 32 | Current status register |
| exc_ret_pc | input | 32 | Saved return address of the normal exception level |
| err_ret_pc | input | 32 | Saved return address of the error level |
| dbg_word | output | 32 | Debug control word |
| dbg_ret_pc | output | 32 | Debug return address, bit 0 holding the mode |
| status_wr_en | output | 1 | Write strobe for the status register |
| status_wr_data | output | 32 | New status value, valid with the strobe |
| redir_vld | output | 1 | Fetch redirect this cycle |
| redir_pc | output | 32 | Redirect target, bit 0 always zero |
| isa_nxt | output | 1 | Instruction-set mode to resume in, valid with the redirect |
| ll_clr | output | 1 | Clear the load-linked flag |

## Verification
The redirect, the target, the resume mode, the status write and the load-linked clear are due in the same cycle as the request, with no register between input and output. The debug control word and the debug return address change only at the clock edge that closes the request's cycle. The bench drives every input just after a falling edge and reads the same-cycle outputs one nanosecond later, against a model computed from the inputs then applied. It compares the two registered outputs against model state that it advances only after the rising edge, so each register result is checked exactly one cycle after its stimulus.

// File: rtl/dbgx_pkg.sv
`timescale 1ns/1ps
package dbgx_pkg;
  localparam int XW = 32;
  localparam int FW = 6;

  // debug control word positions
  localparam int DS_BIT  = 31;
  localparam int DM_BIT  = 30;
  localparam int INH_BIT = 20;
  localparam logic [XW-1:0] TYPE_MASK = 32'h000C_7C3F;

  // status positions
  localparam int ERL_BIT = 2;
  localparam int EXL_BIT = 1;

  localparam logic [XW-1:0] SLOT_STEP = 32'd4;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_ENTRY = 2'd1,
    ACT_DRET  = 2'd2,
    ACT_ERET  = 2'd3
  } act_e;

  function automatic logic [XW-1:0] bit_of(input int pos);
    logic [XW-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  function automatic logic [XW-1:0] entry_word(input logic [XW-1:0] old_w,
                                               input logic [XW-1:0] req_type,
                                               input logic slot);
    logic [XW-1:0] w;
    w = old_w & ~TYPE_MASK;
    w = w | (req_type & TYPE_MASK);
    w = w | bit_of(DM_BIT) | bit_of(INH_BIT);
    w[DS_BIT] = slot;
    return w;
  endfunction

  function automatic logic [XW-1:0] entry_ret(input logic [XW-1:0] pc,
                                              input logic slot,
                                              input logic compact);
    logic [XW-1:0] a;
    a = slot ? (pc - SLOT_STEP) : pc;
    a[0] = a[0] | compact;
    return a;
  endfunction

  function automatic logic [XW-1:0] clear_lsb(input logic [XW-1:0] a);
    return {a[XW-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/dbgx_decode.sv
`timescale 1ns/1ps
module dbgx_decode
  import dbgx_pkg::*;
#(
  parameter logic [FW-1:0] DRET_CODE = 6'h1F,
  parameter logic [FW-1:0] ERET_CODE = 6'h18
) (
  input  logic          dbg_req,
  input  logic          instr_vld,
  input  logic [FW-1:0] cop0_func,
  output act_e          act
);
  logic hit_dret;
  logic hit_eret;

  assign hit_dret = instr_vld && (cop0_func == DRET_CODE);
  assign hit_eret = instr_vld && (cop0_func == ERET_CODE);

  always_comb begin
    if (dbg_req)       act = ACT_ENTRY;
    else if (hit_dret) act = ACT_DRET;
    else if (hit_eret) act = ACT_ERET;
    else               act = ACT_NONE;
  end
endmodule

// File: rtl/dbgx_entry.sv
`timescale 1ns/1ps
module dbgx_entry
  import dbgx_pkg::*;
(
  input  logic [XW-1:0] old_word,
  input  logic [XW-1:0] req_type,
  input  logic          slot,
  input  logic [XW-1:0] pc,
  input  logic          compact,
  output logic [XW-1:0] new_word,
  output logic [XW-1:0] new_ret
);
  assign new_word = entry_word(old_word, req_type, slot);
  assign new_ret  = entry_ret(pc, slot, compact);
endmodule

// File: rtl/dbgx_return.sv
`timescale 1ns/1ps
module dbgx_return
  import dbgx_pkg::*;
(
  input  act_e          act,
  input  logic [XW-1:0] cur_word,
  input  logic [XW-1:0] dbg_ret,
  input  logic [XW-1:0] status_in,
  input  logic [XW-1:0] exc_ret,
  input  logic [XW-1:0] err_ret,
  output logic [XW-1:0] left_word,
  output logic [XW-1:0] ret_addr,
  output logic [XW-1:0] status_new
);
  logic          use_err;
  logic [XW-1:0] lvl_src;
  logic [XW-1:0] lvl_mask;

  assign use_err   = status_in[ERL_BIT];
  assign lvl_src   = use_err ? err_ret : exc_ret;
  assign lvl_mask  = use_err ? bit_of(ERL_BIT) : bit_of(EXL_BIT);
  assign status_new = status_in & ~lvl_mask;
  assign left_word = cur_word & ~(bit_of(DM_BIT) | bit_of(INH_BIT));
  assign ret_addr  = (act == ACT_DRET) ? dbg_ret : lvl_src;
endmodule

// File: rtl/dbgx_unit.sv
`timescale 1ns/1ps
module dbgx_unit
  import dbgx_pkg::*;
#(
  parameter logic [XW-1:0] DBG_VECTOR = 32'hBFC0_0480,
  parameter logic [FW-1:0] DRET_CODE  = 6'h1F,
  parameter logic [FW-1:0] ERET_CODE  = 6'h18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] cur_pc,
  input  logic          cur_compact,
  input  logic          in_slot,
  input  logic          dbg_req,
  input  logic [XW-1:0] dbg_type,
  input  logic          instr_vld,
  input  logic [FW-1:0] cop0_func,
  input  logic [XW-1:0] status_in,
  input  logic [XW-1:0] exc_ret_pc,
  input  logic [XW-1:0] err_ret_pc,
  output logic [XW-1:0] dbg_word,
  output logic [XW-1:0] dbg_ret_pc,
  output logic          status_wr_en,
  output logic [XW-1:0] status_wr_data,
  output logic          redir_vld,
  output logic [XW-1:0] redir_pc,
  output logic          isa_nxt,
  output logic          ll_clr
);
  act_e          act;
  logic [XW-1:0] ent_word;
  logic [XW-1:0] ent_ret;
  logic [XW-1:0] left_word;
  logic [XW-1:0] ret_addr;
  logic [XW-1:0] status_new;
  logic [XW-1:0] raw_tgt;

  dbgx_decode #(.DRET_CODE(DRET_CODE), .ERET_CODE(ERET_CODE)) u_dec (
    .dbg_req   (dbg_req),
    .instr_vld (instr_vld),
    .cop0_func (cop0_func),
    .act       (act)
  );

  dbgx_entry u_ent (
    .old_word (dbg_word),
    .req_type (dbg_type),
    .slot     (in_slot),
    .pc       (cur_pc),
    .compact  (cur_compact),
    .new_word (ent_word),
    .new_ret  (ent_ret)
  );

  dbgx_return u_ret (
    .act        (act),
    .cur_word   (dbg_word),
    .dbg_ret    (dbg_ret_pc),
    .status_in  (status_in),
    .exc_ret    (exc_ret_pc),
    .err_ret    (err_ret_pc),
    .left_word  (left_word),
    .ret_addr   (ret_addr),
    .status_new (status_new)
  );

  assign raw_tgt        = (act == ACT_ENTRY) ? DBG_VECTOR : ret_addr;
  assign redir_vld      = (act != ACT_NONE);
  assign redir_pc       = clear_lsb(raw_tgt);
  assign isa_nxt        = (act != ACT_ENTRY) && raw_tgt[0];
  assign status_wr_en   = (act == ACT_ERET);
  assign status_wr_data = status_new;
  assign ll_clr         = (act == ACT_ERET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_word   <= '0;
      dbg_ret_pc <= '0;
    end else begin
      case (act)
        ACT_ENTRY: begin
          dbg_word   <= ent_word;
          dbg_ret_pc <= ent_ret;
        end
        ACT_DRET: dbg_word <= left_word;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dbgx_unit_chk.sv
`timescale 1ns/1ps
module dbgx_unit_chk
  import dbgx_pkg::*;
#(
  parameter logic [XW-1:0] VEC = 32'hBFC0_0480
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dbg_req,
  input logic          instr_vld,
  input act_e          act,
  input logic [XW-1:0] dbg_word,
  input logic [XW-1:0] dbg_ret_pc,
  input logic          redir_vld,
  input logic [XW-1:0] redir_pc,
  input logic          isa_nxt,
  input logic          status_wr_en,
  input logic          ll_clr
);
  // R3
  entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_ENTRY |=> dbg_word[DM_BIT] && dbg_word[INH_BIT]);

  // R5
  entry_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> redir_vld && redir_pc == VEC && !isa_nxt);

  // R6
  dret_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_DRET |=> !dbg_word[DM_BIT] && !dbg_word[INH_BIT]);

  // R6
  tgt_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld |-> !redir_pc[0]);

  // R4
  ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act != ACT_ENTRY |=> $stable(dbg_ret_pc));

  // R7
  llclr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ll_clr |-> status_wr_en && redir_vld);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_req && !instr_vld |-> !redir_vld && !status_wr_en && !ll_clr);

  // R10
  entry_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> act == ACT_ENTRY && !status_wr_en);
endmodule

bind dbgx_unit dbgx_unit_chk #(.VEC(DBG_VECTOR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dbg_req      (dbg_req),
  .instr_vld    (instr_vld),
  .act          (act),
  .dbg_word     (dbg_word),
  .dbg_ret_pc   (dbg_ret_pc),
  .redir_vld    (redir_vld),
  .redir_pc     (redir_pc),
  .isa_nxt      (isa_nxt),
  .status_wr_en (status_wr_en),
  .ll_clr       (ll_clr)
);

// File: tb/test_dbgx_unit.sv
`timescale 1ns/1ps
module test_dbgx_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cur_pc = '0;
  logic        cur_compact = 1'b0;
  logic        in_slot = 1'b0;
  logic        dbg_req = 1'b0;
  logic [31:0] dbg_type = '0;
  logic        instr_vld = 1'b0;
  logic [5:0]  cop0_func = '0;
  logic [31:0] status_in = '0;
  logic [31:0] exc_ret_pc = '0;
  logic [31:0] err_ret_pc = '0;
  logic [31:0] dbg_word;
  logic [31:0] dbg_ret_pc;
  logic        status_wr_en;
  logic [31:0] status_wr_data;
  logic        redir_vld;
  logic [31:0] redir_pc;
  logic        isa_nxt;
  logic        ll_clr;

  always #2.5 clk = ~clk;

  dbgx_unit i_dbgx_unit (.*);

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string focus = "";

  // model state
  logic [31:0] m_word = '0;
  logic [31:0] m_ret = '0;

  task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // drive one cycle, check same-cycle outputs and held registers, advance model
  task automatic step(input bit req, input logic [31:0] typ, input bit slot,
                      input logic [31:0] pc, input bit comp, input bit iv,
                      input logic [5:0] fn, input logic [31:0] st,
                      input logic [31:0] epc, input logic [31:0] eepc);
    logic [31:0] n_word, n_ret, e_pc, e_sd, src;
    bit e_vld, e_isa, e_sw, e_ll;
    string t;
    @(negedge clk);
    dbg_req = req; dbg_type = typ; in_slot = slot; cur_pc = pc; cur_compact = comp;
    instr_vld = iv; cop0_func = fn; status_in = st; exc_ret_pc = epc; err_ret_pc = eepc;
    #1;
    n_word = m_word; n_ret = m_ret;
    e_vld = 0; e_pc = 0; e_isa = 0; e_sw = 0; e_sd = 0; e_ll = 0;
    if (req) begin
      t = "R5";
      e_vld = 1; e_pc = 32'hBFC00480;
      // type field: bits 0..5, 10..14, 18, 19
      for (int b = 0; b < 32; b++)
        if (b <= 5 || (b >= 10 && b <= 14) || b == 18 || b == 19) n_word[b] = typ[b];
      n_word[30] = 1; n_word[20] = 1; n_word[31] = slot;
      n_ret = (slot ? pc - 4 : pc) | {31'd0, comp};
    end else if (iv && fn == 6'd31) begin
      t = "R6";
      e_vld = 1; e_pc = m_ret - (m_ret % 2); e_isa = m_ret[0];
      n_word[30] = 0; n_word[20] = 0;
    end else if (iv && fn == 6'd24) begin
      t = st[2] ? "R7" : "R8";
      src = st[2] ? eepc : epc;
      e_vld = 1; e_pc = src - (src % 2); e_isa = src[0]; e_sw = 1; e_ll = 1;
      e_sd = st;
      if (st[2]) e_sd[2] = 0; else e_sd[1] = 0;
    end else begin
      t = "R9";
    end
    if (focus != "") t = focus;
    chk({t, " redirect"}, {31'd0, redir_vld}, {31'd0, e_vld});
    if (e_vld) begin
      chk({t, " target"}, redir_pc, e_pc);
      chk({t, " mode"}, {31'd0, isa_nxt}, {31'd0, e_isa});
    end
    chk({t, " status write"}, {31'd0, status_wr_en}, {31'd0, e_sw});
    if (e_sw) chk({t, " status data"}, status_wr_data, e_sd);
    chk({t, " ll clear"}, {31'd0, ll_clr}, {31'd0, e_ll});
    chk("R3 debug word held", dbg_word, m_word);
    chk("R4 return address held", dbg_ret_pc, m_ret);
    @(posedge clk);
    m_word = n_word; m_ret = n_ret;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 debug word", dbg_word, 32'd0);
    chk("R1 return address", dbg_ret_pc, 32'd0);
    chk("R1 redirect", {31'd0, redir_vld}, 32'd0);
    chk("R1 status write", {31'd0, status_wr_en}, 32'd0);
    chk("R1 ll clear", {31'd0, ll_clr}, 32'd0);
    rst_n = 1'b1;

    // entry in a delay slot, compressed mode, all type bits requested
    focus = "R3";
    step(1, 32'hFFFF_FFFF, 1, 32'h8000_1004, 1, 0, 0, 0, 0, 0);
    // re-entry while in debug mode: type field rewritten
    focus = "R2";
    step(1, 32'h0000_0002, 0, 32'h8000_2000, 0, 0, 0, 0, 0, 0);
    step(1, 32'hFFF0_0400, 0, 32'h8000_2010, 1, 0, 0, 0, 0, 0);
    focus = "R6";
    step(0, 0, 0, 0, 0, 1, 6'h1F, 0, 0, 0);
    focus = "R9";
    step(0, 0, 0, 0, 0, 1, 6'h20, 32'h6, 32'h1234, 32'h5678);
    step(0, 0, 0, 0, 0, 0, 6'h18, 32'h6, 32'h1234, 32'h5678);
    focus = "R7";
    step(0, 0, 0, 0, 0, 1, 6'h18, 32'h0000_0006, 32'h8000_0200, 32'h9000_0003);
    focus = "R8";
    step(0, 0, 0, 0, 0, 1, 6'h18, 32'hFFFF_FFFB, 32'h8000_0201, 32'h9000_0000);
    focus = "R10";
    step(1, 32'h10, 1, 32'h8000_3000, 0, 1, 6'h1F, 0, 0, 0);
    step(1, 32'h1, 0, 32'h8000_3100, 0, 1, 6'h18, 32'h4, 32'h11, 32'h22);
    focus = "R6";
    step(0, 0, 0, 0, 0, 1, 6'h1F, 0, 0, 0);
    focus = "R5";
    step(1, 32'h20, 0, 32'h0000_0100, 0, 0, 0, 0, 0, 0);

    focus = "";
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] fn;
      int pick;
      pick = $urandom_range(0, 3);
      fn = (pick == 0) ? 6'h1F : (pick == 1) ? 6'h18 : (pick == 2) ? 6'h20 : 6'($urandom);
      step($urandom_range(0, 3) == 0, $urandom, 1'($urandom), $urandom & 32'hFFFF_FFFE,
           1'($urandom), 1'($urandom), fn, $urandom, $urandom, $urandom);
    end

    @(negedge clk);
    dbg_req = 0; instr_vld = 0;
    #1;
    chk("R3 final debug word", dbg_word, m_word);
    chk("R4 final return address", dbg_ret_pc, m_ret);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule